// File: doc/BRIEF.md
# Coarse-to-Fine Frequency Acquisition Controller

This block drives the frequency control code of a digitally controlled oscillator toward a target frequency. A rising edge on the loss-of-lock request forces the code to the bottom of its range and starts a search. Once per measurement window a signed frequency error arrives, in ppm, with a valid strobe. While the oscillator is below the target, the code is raised by the current step. The step starts at half the code range and shrinks as the error closes.

An overshoot puts the code back to the last value known to lie below the target and halves the step. The result is a restoring successive approximation whose only forward moves are upward. When the error magnitude falls inside the lock window, the search stops and freezes the code. A handoff output then enables the downstream phase/delay loop, which pulls in the rest of the error. A new rising edge on the loss-of-lock request restarts the search from any state.

Top module: `freq_acq_ctrl`

## Requirements
- R1: While rst_ni is low, code_o is 0, busy_o is 0 and handoff_o is 0.
- R2: In the cycle after a rising edge of lol_i, code_o is 0, busy_o is 1 and handoff_o is 0, whatever the state was, and even if err_valid_i is high in that cycle. The internal step is reloaded with 2^(CODE_W-1).
- R3: code_o changes only on a clock edge where err_valid_i is high during a search, or where R2 applies. In idle, err_valid_i has no effect.
- R4: err_i is a two's complement ppm value, positive when the oscillator is below the target. During a search, a valid error greater than LOCK_PPM raises code_o by the current step. The sum saturates at 2^CODE_W-1 and never wraps.
- R5: During a search, a valid error below -LOCK_PPM returns code_o to its value before the last raise, which is 0 if there was no raise. The code is never raised in that case. The most negative input value is handled this way as well.
- R6: The step halves after every overshoot, and after every raise whose error magnitude is below FINE_PPM. It never goes below 1. The first raise after a start therefore moves the code by 2^(CODE_W-1).
- R7: During a search, a valid error with magnitude at most LOCK_PPM ends the search. In the next cycle busy_o is 0, handoff_o is 1, and code_o is unchanged.
- R8: After the handoff, code_o and handoff_o hold and valid errors are ignored until the next rising edge of lol_i.
- R9: busy_o and handoff_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lol_i | input | 1 | Loss-of-lock request; a rising edge starts a search |
| err_valid_i | input | 1 | Strobe, one per measurement window |
| err_i | input | ERR_W | Signed frequency error in ppm (target minus oscillator) |
| code_o | output | CODE_W | Oscillator frequency control code |
| busy_o | output | 1 | Search in progress |
| handoff_o | output | 1 | Frequency loop done; enables the phase/delay loop |

## Verification
The bench runs a closed loop with a behavioural oscillator model. It aims at a target beyond the code range, which shows whether the sum wraps to a low code instead of pinning at the top. It restarts during a search while a strobe is present in the same cycle. A design that ranks the strobe above the restart would leave a nonzero code in that case. It feeds the most negative error value, which exposes a magnitude computation that overflows and reports false lock. It also sends errors during idle, during strobe gaps and after the handoff, where any code movement or dropped handoff points to a missing qualifier.

// File: rtl/freq_acq_pkg.sv
package freq_acq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_LOCKED = 2'd2
  } acq_state_e;

  typedef struct packed {
    logic in_lock;
    logic fine;
    logic below;
  } err_class_t;
endpackage

// File: rtl/freq_acq_edge.sv
module freq_acq_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/freq_acq_err_class.sv
module freq_acq_err_class
  import freq_acq_pkg::*;
#(
  parameter int ERR_W    = 16,
  parameter int LOCK_PPM = 250,
  parameter int FINE_PPM = 2000
) (
  input  logic [ERR_W-1:0] err_i,
  output err_class_t       class_o
);
  localparam int EXT_W = ERR_W + 1;
  localparam logic [EXT_W-1:0] LOCK_L = EXT_W'(LOCK_PPM);

  logic [EXT_W-1:0] ext;
  logic [EXT_W-1:0] mag;

  // one extra bit keeps the most negative value's magnitude exact
  assign ext = {err_i[ERR_W-1], err_i};
  assign mag = ext[EXT_W-1] ? (~ext + 1'b1) : ext;

  assign class_o.in_lock = (mag <= LOCK_L);
  assign class_o.below   = ~err_i[ERR_W-1] & (|err_i);

  generate
    if (FINE_PPM > 0) begin : g_fine
      localparam logic [EXT_W-1:0] FINE_L = EXT_W'(FINE_PPM);
      assign class_o.fine = (mag < FINE_L);
    end else begin : g_no_fine
      assign class_o.fine = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/freq_acq_step_ctrl.sv
module freq_acq_step_ctrl #(
  parameter int CODE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shrink_i,
  output logic [CODE_W-1:0] step_o
);
  localparam logic [CODE_W-1:0] STEP_INIT = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [CODE_W-1:0] STEP_MIN  = {{(CODE_W-1){1'b0}}, 1'b1};

  logic [CODE_W-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            step_q <= STEP_INIT;
    else if (load_i)                        step_q <= STEP_INIT;
    else if (shrink_i && step_q > STEP_MIN) step_q <= step_q >> 1;
  end

  assign step_o = step_q;
endmodule

// File: rtl/freq_acq_code_reg.sv
module freq_acq_code_reg #(
  parameter int CODE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              raise_i,
  input  logic              retract_i,
  input  logic [CODE_W-1:0] step_i,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] base_q;  // last code known below target
  logic [CODE_W:0]   sum;
  logic [CODE_W-1:0] sat;

  assign sum = {1'b0, code_q} + {1'b0, step_i};
  assign sat = sum[CODE_W] ? CODE_MAX : sum[CODE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      base_q <= '0;
    end else if (clear_i) begin
      code_q <= '0;
      base_q <= '0;
    end else if (raise_i) begin
      base_q <= code_q;
      code_q <= sat;
    end else if (retract_i) begin
      code_q <= base_q;
    end
  end

  assign code_o = code_q;
endmodule

// File: rtl/freq_acq_ctrl.sv
module freq_acq_ctrl
  import freq_acq_pkg::*;
#(
  parameter int CODE_W   = 10,
  parameter int ERR_W    = 16,
  parameter int LOCK_PPM = 250,
  parameter int FINE_PPM = 2000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lol_i,
  input  logic              err_valid_i,
  input  logic [ERR_W-1:0]  err_i,
  output logic [CODE_W-1:0] code_o,
  output logic              busy_o,
  output logic              handoff_o
);
  acq_state_e        state_q, state_d;
  err_class_t        err_cls;
  logic              lol_start;
  logic              meas;
  logic              raise;
  logic              retract;
  logic              shrink;
  logic [CODE_W-1:0] step;

  freq_acq_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lol_i),
    .rise_o (lol_start)
  );

  freq_acq_err_class #(
    .ERR_W    (ERR_W),
    .LOCK_PPM (LOCK_PPM),
    .FINE_PPM (FINE_PPM)
  ) u_cls (
    .err_i   (err_i),
    .class_o (err_cls)
  );

  // a start outranks any measurement in the same cycle
  assign meas    = (state_q == ST_SEARCH) & err_valid_i & ~lol_start;
  assign raise   = meas & ~err_cls.in_lock & err_cls.below;
  assign retract = meas & ~err_cls.in_lock & ~err_cls.below;
  assign shrink  = retract | (raise & err_cls.fine);

  freq_acq_step_ctrl #(
    .CODE_W (CODE_W)
  ) u_step (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (lol_start),
    .shrink_i (shrink),
    .step_o   (step)
  );

  freq_acq_code_reg #(
    .CODE_W (CODE_W)
  ) u_code (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (lol_start),
    .raise_i   (raise),
    .retract_i (retract),
    .step_i    (step),
    .code_o    (code_o)
  );

  always_comb begin
    state_d = state_q;
    if (lol_start)                   state_d = ST_SEARCH;
    else if (meas && err_cls.in_lock) state_d = ST_LOCKED;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign busy_o    = (state_q == ST_SEARCH);
  assign handoff_o = (state_q == ST_LOCKED);
endmodule

// File: rtl/freq_acq_ctrl_chk.sv
module freq_acq_ctrl_chk #(
  parameter int CODE_W   = 10,
  parameter int ERR_W    = 16,
  parameter int LOCK_PPM = 250
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lol_start_i,
  input logic              err_valid_i,
  input logic [ERR_W-1:0]  err_i,
  input logic [CODE_W-1:0] code_o,
  input logic              busy_o,
  input logic              handoff_o
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  logic signed [ERR_W-1:0] err_s;
  assign err_s = $signed(err_i);

  // R9
  busy_handoff_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && handoff_o));

  // R2
  start_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lol_start_i |=> (code_o == '0) && busy_o && !handoff_o);

  // R3
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lol_start_i && !(busy_o && err_valid_i)) |=> $stable(code_o));

  // R4
  raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && err_valid_i && !lol_start_i && err_s > LOCK_PPM && code_o != CODE_MAX)
    |=> code_o > $past(code_o));

  // R4
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && err_valid_i && !lol_start_i && err_s > LOCK_PPM)
    |=> code_o >= $past(code_o));

  // R5
  no_raise_above_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && err_valid_i && !lol_start_i && err_s < -LOCK_PPM)
    |=> code_o <= $past(code_o));

  // R7
  lock_handoff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && err_valid_i && !lol_start_i && err_s <= LOCK_PPM && err_s >= -LOCK_PPM)
    |=> handoff_o && !busy_o && $stable(code_o));

  // R8
  locked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (handoff_o && !lol_start_i) |=> handoff_o && $stable(code_o));
endmodule

bind freq_acq_ctrl freq_acq_ctrl_chk #(
  .CODE_W   (CODE_W),
  .ERR_W    (ERR_W),
  .LOCK_PPM (LOCK_PPM)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lol_start_i (lol_start),
  .err_valid_i (err_valid_i),
  .err_i       (err_i),
  .code_o      (code_o),
  .busy_o      (busy_o),
  .handoff_o   (handoff_o)
);

// File: tb/freq_acq_ctrl_tb.sv
module freq_acq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W     = 10;
  localparam int ERR_W      = 16;
  localparam int LOCK_PPM   = 250;
  localparam int FINE_PPM   = 2000;
  localparam int PPM_CODE   = 100;
  localparam int CODE_MAX   = (1 << CODE_W) - 1;
  localparam int STEP_INIT  = 1 << (CODE_W - 1);
  localparam int ERR_LIM    = (1 << (ERR_W - 1)) - 1;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              lol_i = 1'b0;
  logic              err_valid_i = 1'b0;
  logic [ERR_W-1:0]  err_i = '0;
  logic [CODE_W-1:0] code_o;
  logic              busy_o;
  logic              handoff_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // reference model state
  int    m_code = 0, m_base = 0, m_step = STEP_INIT, m_st = 0;
  bit    m_prev = 1'b0;
  string m_tag = "R1";

  freq_acq_ctrl #(
    .CODE_W   (CODE_W),
    .ERR_W    (ERR_W),
    .LOCK_PPM (LOCK_PPM),
    .FINE_PPM (FINE_PPM)
  ) u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lol_i       (lol_i),
    .err_valid_i (err_valid_i),
    .err_i       (err_i),
    .code_o      (code_o),
    .busy_o      (busy_o),
    .handoff_o   (handoff_o)
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  always @(posedge clk_i) begin : model
    int e, a;
    bit go;
    cyc++;
    if (!rst_ni) begin
      m_code = 0; m_base = 0; m_step = STEP_INIT; m_st = 0; m_prev = 1'b0; m_tag = "R1";
    end else begin
      go = lol_i && !m_prev;
      m_prev = lol_i;
      e = $signed(err_i);
      a = (e < 0) ? -e : e;
      if (go) begin
        m_code = 0; m_base = 0; m_step = STEP_INIT; m_st = 1; m_tag = "R2";
      end else if (m_st == 1 && err_valid_i) begin
        if (a <= LOCK_PPM) begin
          m_st = 2; m_tag = "R7";
        end else if (e > 0) begin
          m_base = m_code;
          m_code = (m_code + m_step > CODE_MAX) ? CODE_MAX : m_code + m_step;
          if (a < FINE_PPM && m_step > 1) m_step = m_step / 2;
          m_tag = "R4";
        end else begin
          m_code = m_base;
          if (m_step > 1) m_step = m_step / 2;
          m_tag = "R5";
        end
      end else begin
        m_tag = (m_st == 2) ? "R8" : "R3";
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    check(int'(code_o) == m_code, m_tag, code_o, m_code);
    check(busy_o == (m_st == 1), m_tag, busy_o, m_st == 1);
    check(handoff_o == (m_st == 2), m_tag, handoff_o, m_st == 2);
    check(!(busy_o && handoff_o), "R9", busy_o & handoff_o, 0);
  endtask

  function automatic int osc_err(input int tgt);
    int e;
    e = (tgt - int'(code_o)) * PPM_CODE;
    if (e > ERR_LIM) e = ERR_LIM;
    if (e < -ERR_LIM) e = -ERR_LIM;
    return e;
  endfunction

  // compare, then drive the next inputs, all at the falling edge
  task automatic tick(input logic lol, input logic v, input int e);
    @(negedge clk_i);
    compare();
    lol_i = lol;
    err_valid_i = v;
    err_i = e[ERR_W-1:0];
  endtask

  task automatic run_loop(input int tgt, input int n, input bit stop_on_lock);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      compare();
      if (stop_on_lock && handoff_o) begin
        err_valid_i = 1'b0;
        break;
      end
      lol_i = 1'b1;
      err_valid_i = i[0];  // strobe every second cycle
      err_i = osc_err(tgt)[ERR_W-1:0];
    end
  endtask

  task automatic restart();
    tick(1'b0, 1'b0, 0);
    tick(1'b1, 1'b0, 0);
    tick(1'b1, 1'b0, 0);
  endtask

  initial begin : watchdog
    wait (cyc > 20000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    tick(1'b0, 1'b1, 4000);
    tick(1'b0, 1'b1, 4000);
    check(code_o == '0 && !busy_o && !handoff_o, "R1", {busy_o, handoff_o, code_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R3: strobes in idle are ignored
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b1, 5000);
    tick(1'b0, 1'b0, 0);
    check(code_o == '0 && !busy_o, "R3", code_o, 0);

    // R2: start from idle
    tick(1'b1, 1'b0, 0);
    tick(1'b1, 1'b0, 0);
    check(busy_o && code_o == '0, "R2", busy_o, 1);

    // R6: first raise uses half range
    tick(1'b1, 1'b1, 30000);
    tick(1'b1, 1'b0, 0);
    check(int'(code_o) == STEP_INIT, "R6", code_o, STEP_INIT);

    // closed loop toward an in-range target, with strobe gaps
    run_loop(300, 200, 1'b1);
    check(handoff_o && !busy_o, "R7", handoff_o, 1);
    check(int'(code_o) >= 298 && int'(code_o) <= 302, "R6", code_o, 300);

    // R8: strobes after lock ignored
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b1, -9000);
    tick(1'b1, 1'b0, 0);
    check(handoff_o && int'(code_o) >= 298 && int'(code_o) <= 302, "R8", code_o, 300);

    // R2: restart from lock, then target beyond range saturates (R4)
    restart();
    check(code_o == '0 && busy_o && !handoff_o, "R2", code_o, 0);
    run_loop(1200, 80, 1'b0);
    check(int'(code_o) == CODE_MAX && busy_o, "R4", code_o, CODE_MAX);

    // R2: restart mid-search with a strobe in the same cycle
    restart();
    run_loop(37, 6, 1'b0);
    tick(1'b0, 1'b0, 0);
    tick(1'b1, 1'b1, 20000);
    tick(1'b1, 1'b0, 0);
    check(code_o == '0 && busy_o, "R2", code_o, 0);
    run_loop(37, 200, 1'b1);
    check(handoff_o && int'(code_o) >= 35 && int'(code_o) <= 39, "R7", code_o, 37);

    // R5: most negative error from the bottom keeps code at 0, step halves
    restart();
    tick(1'b1, 1'b1, -32768);
    tick(1'b1, 1'b0, 0);
    check(code_o == '0 && busy_o, "R5", code_o, 0);
    tick(1'b1, 1'b1, 3000);
    tick(1'b1, 1'b0, 0);
    check(int'(code_o) == STEP_INIT / 2, "R6", code_o, STEP_INIT / 2);

    // R7: zero error at start locks immediately with code 0
    restart();
    tick(1'b1, 1'b1, 0);
    tick(1'b1, 1'b0, 0);
    check(handoff_o && code_o == '0 && !busy_o, "R7", handoff_o, 1);

    tick(1'b1, 1'b0, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule